// File: doc/BRIEF.md
# UART Modem Handshake Line Controller

This block looks after the handshake lines of a UART-style serial controller. A host reaches it through a simple synchronous register port. The host sets a control word that drives the active-low request-to-send pin. The host reads back a status word that shows the synchronized ring-indicator level and a sticky flag. The flag records each low-to-high ring-indicator transition. A modem-status interrupt can be enabled so that such a transition raises an interrupt line. The interrupt stays up until the status word is read.

Three conditions can override the request-to-send pin and hold it inactive (high):

- reset;
- a loopback mode that isolates the pin;
- an automatic flow-control mode. In this mode the pin is released whenever the receiver FIFO fill level, supplied as an input, is at or above a programmed threshold. The pin returns as soon as the fill level drops back below the threshold.

The register map has four 8-bit words:

| Address | Word |
|---|---|
| 0 | control |
| 1 | status |
| 2 | interrupt enable |
| 3 | threshold |

Read data is combinational from the current state.

Top module: `uart_modem_line`

## Requirements
- R1: While reset is active and right after it, rtsN is 1 and modemIrq is 0. The control, interrupt-enable and threshold words read 0, and status bit 2 reads 0.
- R2: With control bits 4 and 5 clear, rtsN equals the inverse of control bit 1. Each write to address 0 is reflected on rtsN two rising edges after the write cycle begins.
- R3: With control bit 4 (loopback) set, rtsN is 1 whatever bit 1 and the fill level are.
- R4: With control bit 5 (auto flow) set, rtsN is 1 when rxLevel is at or above the threshold word (address 3). Otherwise rtsN follows R2. A change of rxLevel shows on rtsN after one rising edge.
- R5: Status bit 6 reads the ring-indicator input level after a two-stage synchronizer, two rising edges after the input changes.
- R6: Status bit 2 becomes 1 three rising edges after a low-to-high ring-indicator transition and stays 1 until a status read. A high-to-low transition does not set it.
- R7: A status read returns the value held before the read and clears bit 2 and any pending interrupt at the end of that cycle. A rising transition detected in that same cycle is kept, not lost.
- R8: modemIrq rises together with status bit 2 when interrupt-enable bit 0 is set at the time of the transition. It stays 0 for a transition that occurs while that bit is clear.
- R9: The control word (bits 1, 4, 5), interrupt-enable bit 0 and the threshold word read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; a read of address 1 clears the sticky state |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr, combinational |
| riIn | input | 1 | Ring-indicator input, asynchronous |
| rxLevel | input | LVL_W | Receiver FIFO fill level |
| rtsN | output | 1 | Request-to-send pin, active low, registered |
| modemIrq | output | 1 | Modem-status interrupt, active high |

## Verification
Each result has a fixed latency:

| Result | Due |
|---|---|
| rtsN after a control or threshold write | second rising edge after the write cycle starts |
| rtsN after an rxLevel change | next rising edge |
| ring-indicator level in the status word | second edge after riIn changes |
| change flag and interrupt | third edge after riIn changes |

The bench drives inputs on falling edges and samples at least that many falling edges later, so every sample falls after the last register on the path has settled. The same-cycle read-and-transition case is lined up so that the read strobe covers exactly the edge on which the flag would be set.

// File: rtl/uart_modem_pkg.sv
package uart_modem_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_IEN  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_THR  = 2'd3;

  // bit positions inside the control and status words
  localparam int CTRL_RTS_BIT  = 1;
  localparam int CTRL_LOOP_BIT = 4;
  localparam int CTRL_AUTO_BIT = 5;
  localparam int STAT_DRI_BIT  = 2;
  localparam int STAT_RI_BIT   = 6;
  localparam int IEN_MS_BIT    = 0;

  typedef struct packed {
    logic wrCtrl;
    logic wrIen;
    logic wrThr;
    logic rdStat;
  } modemStrb_t;
endpackage

// File: rtl/uart_modem_ctrl.sv
module uart_modem_ctrl
  import uart_modem_pkg::*;
(
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output modemStrb_t        strb
);
  always_comb begin
    strb        = '0;
    strb.wrCtrl = regWrEn && (regAddr == ADDR_CTRL);
    strb.wrIen  = regWrEn && (regAddr == ADDR_IEN);
    strb.wrThr  = regWrEn && (regAddr == ADDR_THR);
    strb.rdStat = regRdEn && (regAddr == ADDR_STAT);
  end
endmodule

// File: rtl/uart_modem_dp.sv
module uart_modem_dp
  import uart_modem_pkg::*;
#(
  parameter int LVL_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  modemStrb_t        strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              riIn,
  input  logic [LVL_W-1:0]  rxLevel,
  output logic [DATA_W-1:0] regRdData,
  output logic              rtsN,
  output logic              modemIrq,
  output logic              rtsReq,
  output logic              loopMode,
  output logic              autoMode,
  output logic [LVL_W-1:0]  rxThresh
);
  localparam int PAD_W = DATA_W - LVL_W;

  logic                   msIen;
  logic [SYNC_STAGES-1:0] riSync;
  logic                   riLvl;
  logic                   riPrev;
  logic                   riRise;
  logic                   riDelta;
  logic                   irqPend;
  logic                   autoHold;
  logic                   rtsOff;

  // control, enable and threshold registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rtsReq   <= 1'b0;
      loopMode <= 1'b0;
      autoMode <= 1'b0;
      msIen    <= 1'b0;
      rxThresh <= '0;
    end else begin
      if (strb.wrCtrl) begin
        rtsReq   <= regWrData[CTRL_RTS_BIT];
        loopMode <= regWrData[CTRL_LOOP_BIT];
        autoMode <= regWrData[CTRL_AUTO_BIT];
      end
      if (strb.wrIen) msIen <= regWrData[IEN_MS_BIT];
      if (strb.wrThr) rxThresh <= regWrData[LVL_W-1:0];
    end
  end

  // ring-indicator synchronizer chain
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) riSync <= '0;
        else       riSync <= riIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) riSync <= '0;
        else       riSync <= {riSync[SYNC_STAGES-2:0], riIn};
      end
    end
  endgenerate

  assign riLvl  = riSync[SYNC_STAGES-1];
  assign riRise = riLvl && !riPrev;

  // sticky change flag and pending interrupt; a new edge wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riPrev  <= 1'b0;
      riDelta <= 1'b0;
      irqPend <= 1'b0;
    end else begin
      riPrev  <= riLvl;
      riDelta <= riRise || (riDelta && !strb.rdStat);
      irqPend <= (riRise && msIen) || (irqPend && !strb.rdStat);
    end
  end

  assign modemIrq = irqPend;

  // request-to-send pin with its three overrides
  assign autoHold = autoMode && (rxLevel >= rxThresh);
  assign rtsOff   = loopMode || autoHold || !rtsReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rtsN <= 1'b1;
    else       rtsN <= rtsOff;
  end

  // read mux
  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_CTRL: begin
        regRdData[CTRL_RTS_BIT]  = rtsReq;
        regRdData[CTRL_LOOP_BIT] = loopMode;
        regRdData[CTRL_AUTO_BIT] = autoMode;
      end
      ADDR_STAT: begin
        regRdData[STAT_RI_BIT]  = riLvl;
        regRdData[STAT_DRI_BIT] = riDelta;
      end
      ADDR_IEN:  regRdData[IEN_MS_BIT] = msIen;
      default:   regRdData = {{PAD_W{1'b0}}, rxThresh};
    endcase
  end
endmodule

// File: rtl/uart_modem_line.sv
module uart_modem_line
  import uart_modem_pkg::*;
#(
  parameter int LVL_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              riIn,
  input  logic [LVL_W-1:0]  rxLevel,
  output logic              rtsN,
  output logic              modemIrq
);
  modemStrb_t       strb;
  logic             rtsReq;
  logic             loopMode;
  logic             autoMode;
  logic [LVL_W-1:0] rxThresh;

  uart_modem_ctrl ctrl_i (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  uart_modem_dp #(.LVL_W(LVL_W), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .riIn      (riIn),
    .rxLevel   (rxLevel),
    .regRdData (regRdData),
    .rtsN      (rtsN),
    .modemIrq  (modemIrq),
    .rtsReq    (rtsReq),
    .loopMode  (loopMode),
    .autoMode  (autoMode),
    .rxThresh  (rxThresh)
  );
endmodule

// File: rtl/uart_modem_line_chk.sv
module uart_modem_line_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             riIn,
  input logic [LVL_W-1:0] rxLevel,
  input logic             rtsN,
  input logic             modemIrq,
  input logic             rtsReq,
  input logic             loopMode,
  input logic             autoMode,
  input logic [LVL_W-1:0] rxThresh
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (rtsN && !modemIrq));

  // R2
  rts_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loopMode && !autoMode) |=> (rtsN == !$past(rtsReq)));

  // R3
  loop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    loopMode |=> rtsN);

  // R4
  auto_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (autoMode && (rxLevel >= rxThresh)) |=> rtsN);

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modemIrq) |-> ($past(riIn, 3) && !$past(riIn, 4)));
endmodule

bind uart_modem_line uart_modem_line_chk #(.LVL_W(LVL_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .riIn     (riIn),
  .rxLevel  (rxLevel),
  .rtsN     (rtsN),
  .modemIrq (modemIrq),
  .rtsReq   (rtsReq),
  .loopMode (loopMode),
  .autoMode (autoMode),
  .rxThresh (rxThresh)
);

// File: tb/uart_modem_line_tb_top.sv
`timescale 1ns/1ps
module uart_modem_line_tb_top;
  localparam int LVL_W = 5;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regWrEn = 1'b0;
  logic             regRdEn = 1'b0;
  logic [1:0]       regAddr = '0;
  logic [7:0]       regWrData = '0;
  logic [7:0]       regRdData;
  logic             riIn = 1'b0;
  logic [LVL_W-1:0] rxLevel = '0;
  logic             rtsN;
  logic             modemIrq;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  uart_modem_line #(.LVL_W(LVL_W)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .riIn(riIn), .rxLevel(rxLevel), .rtsN(rtsN), .modemIrq(modemIrq)
  );

  function automatic logic expRts(input logic [7:0] c, input logic [LVL_W-1:0] thr,
                                  input logic [LVL_W-1:0] lvl);
    if (c[4]) return 1'b1;
    if (c[5] && (lvl >= thr)) return 1'b1;
    return !c[1];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    logic [7:0] c;
    logic [LVL_W-1:0] thr;
    void'($urandom(32'd4711));

    waitNeg(3);
    // R1 reset state
    check("R1 rtsN in reset", {7'b0, rtsN}, 8'h01);
    check("R1 irq in reset", {7'b0, modemIrq}, 8'h00);
    rstN = 1'b1;
    waitNeg(1);
    check("R1 rtsN after reset", {7'b0, rtsN}, 8'h01);
    peek(2'd0, d); check("R1 ctrl word", d, 8'h00);
    peek(2'd2, d); check("R1 ien word", d, 8'h00);
    peek(2'd3, d); check("R1 thr word", d, 8'h00);
    peek(2'd1, d); check("R1 status", d, 8'h00);

    // R2 plain control
    wrReg(2'd0, 8'h02);
    check("R2 one edge after write", {7'b0, rtsN}, 8'h01);
    waitNeg(1);
    check("R2 rts active", {7'b0, rtsN}, 8'h00);
    wrReg(2'd0, 8'h00); waitNeg(1);
    check("R2 rts inactive", {7'b0, rtsN}, 8'h01);

    // R3 loopback
    wrReg(2'd0, 8'h12); waitNeg(1);
    check("R3 loop holds rts", {7'b0, rtsN}, 8'h01);

    // R9 readback
    wrReg(2'd3, 8'h08);
    wrReg(2'd2, 8'h01);
    peek(2'd0, d); check("R9 ctrl readback", d, 8'h12);
    peek(2'd3, d); check("R9 thr readback", d, 8'h08);
    peek(2'd2, d); check("R9 ien readback", d, 8'h01);

    // R4 auto flow at threshold boundary
    wrReg(2'd0, 8'h22);
    rxLevel = 5'd7; waitNeg(2);
    check("R4 below threshold", {7'b0, rtsN}, 8'h00);
    rxLevel = 5'd8; waitNeg(1);
    check("R4 at threshold", {7'b0, rtsN}, 8'h01);
    rxLevel = 5'd7; waitNeg(1);
    check("R4 back below", {7'b0, rtsN}, 8'h00);

    // R5/R6/R8 ring indicator with interrupt enabled
    riIn = 1'b1;
    waitNeg(2);
    peek(2'd1, d); check("R5 level after two edges", d & 8'h40, 8'h40);
    check("R6 flag not yet", d & 8'h04, 8'h00);
    waitNeg(1);
    peek(2'd1, d); check("R6 flag set", d & 8'h04, 8'h04);
    check("R8 irq raised", {7'b0, modemIrq}, 8'h01);
    waitNeg(5);
    peek(2'd1, d); check("R6 flag sticky", d & 8'h04, 8'h04);
    rdReg(2'd1, d); check("R7 read returns pre-clear", d, 8'h44);
    peek(2'd1, d); check("R7 flag cleared", d, 8'h40);
    check("R7 irq cleared", {7'b0, modemIrq}, 8'h00);
    riIn = 1'b0; waitNeg(4);
    peek(2'd1, d); check("R6 falling edge sets nothing", d, 8'h00);

    // R7 transition in the same cycle as the clearing read
    riIn = 1'b1; waitNeg(4);
    riIn = 1'b0; waitNeg(4);
    peek(2'd1, d); check("R7 setup flag", d & 8'h04, 8'h04);
    riIn = 1'b1;
    waitNeg(2);
    regRdEn = 1'b1; regAddr = 2'd1;
    @(negedge clk);
    regRdEn = 1'b0;
    peek(2'd1, d); check("R7 coinciding edge kept", d & 8'h04, 8'h04);
    check("R7 coinciding irq kept", {7'b0, modemIrq}, 8'h01);
    rdReg(2'd1, d);
    riIn = 1'b0; waitNeg(4);

    // R8 disabled interrupt
    wrReg(2'd2, 8'h00);
    riIn = 1'b1; waitNeg(4);
    peek(2'd1, d); check("R8 flag without enable", d & 8'h04, 8'h04);
    check("R8 irq stays low", {7'b0, modemIrq}, 8'h00);
    rdReg(2'd1, d);
    riIn = 1'b0; waitNeg(4);

    // random mix for R2 R3 R4
    for (int k = 0; k < 200; k++) begin
      c   = 8'($urandom) & 8'h32;
      thr = LVL_W'($urandom_range(0, 16));
      wrReg(2'd0, c);
      wrReg(2'd3, {3'b0, thr});
      rxLevel = LVL_W'($urandom_range(0, 16));
      waitNeg(2);
      check("R2 R3 R4 random rts", {7'b0, rtsN}, {7'b0, expRts(c, thr, rxLevel)});
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule